// File: doc/BRIEF.md
# Chopper and Element-Rotation Controller

This block derives every digital control line that a precision sensor front end needs for offset chopping and dynamic element matching, all from one master clock. A tick counter splits the master clock into modulator cycles. Two window decoders turn each cycle into a pair of non-overlapping modulator clock phases, each with a companion copy whose falling edge comes late. A cycle sequencer drives the fast chop, the bias-ratio swap and the feedback-polarity swap once per modulator cycle. It also drives a slow outer chop and a one-hot select that picks which of the unit bias sources is set against the others.

The fast chop swaps the two sensing transistors between a 3:1 and a 1:3 bias ratio. The feedback swap flips the output connection in the same clock so the loop polarity stays correct. The rotation select serves the bias sources and also the element matching of a separate 3:1 mirror. Slow-chop and rotation changes only ever happen at the start of a modulator cycle, so every modulator cycle holds whole chop states. All rates come from parameters, so the slow chop can be placed on the first null of the decimation filter.

Top module: `chop_rotation_ctrl`

## Requirements
- R1: While rst_n is low, every phase output and the fast chop, ratio swap, feedback swap and slow chop outputs are 0, and unit_sel is 0001 (unit 0). Asserting rst_n forces these values without waiting for a clock edge.
- R2: Reset release is synchronised. Outputs keep their reset values through the first two rising edges after rst_n goes high, and the first modulator cycle shows at the outputs after the third edge.
- R3: A modulator cycle is CYC_LEN clocks long, with tick t running from 0 to CYC_LEN-1. With HALF = CYC_LEN/2, phi1 is high for t < HALF-GAP and phi2 is high for HALF <= t < CYC_LEN-GAP.
- R4: No two of the phases overlap. This includes the late copies: phi1 and phi1_late are never high together with phi2 or phi2_late.
- R5: phi1_late and phi2_late rise in the same clock as phi1 and phi2 and fall DLY clocks after them, with DLY < GAP.
- R6: fast_chop is 0 in modulator cycle 0 and toggles at the start of every later cycle, in the clock where phi1 rises.
- R7: ratio_swap (1 = bias ratio 1:3) and fb_swap (1 = feedback taken at the other base) always equal fast_chop.
- R8: slow_chop equals (k / SLOW_CYCLES) mod 2 for modulator cycle k, so it changes only at a cycle start.
- R9: unit_sel is one-hot. Its bit (k / ROT_CYCLES) mod NUM_UNITS is set, so it advances only at a cycle start.
- R10: Over a whole rotation of NUM_UNITS*ROT_CYCLES cycles, every unit is singled out for the same number of clocks. With ROT_CYCLES even, each unit spends half of those clocks with the ratio swapped.
- R11: A reset asserted in the middle of a run restarts the whole sequence from cycle 0, tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi1 | output | 1 | First modulator clock phase |
| phi1_late | output | 1 | phi1 with a delayed falling edge |
| phi2 | output | 1 | Second modulator clock phase |
| phi2_late | output | 1 | phi2 with a delayed falling edge |
| fast_chop | output | 1 | Inner chopper control, one state per modulator cycle |
| ratio_swap | output | 1 | Selects a 1:3 bias ratio instead of 3:1 |
| fb_swap | output | 1 | Moves the feedback connection to the other transistor base |
| slow_chop | output | 1 | Outer chopper control |
| unit_sel | output | NUM_UNITS | One-hot select of the singled-out unit source |

## Verification
The bench follows the free-running timeline from reset release over several slow-chop periods and many full rotations, comparing every output in every clock with an independent model. This separates errors in phase widths and gaps from errors in the late falling edges, and errors in cycle-boundary timing from errors in the counting of the slow chop and the rotation. Per-unit clock counts taken over two whole rotations, split by ratio state, show whether the rotation is balanced. An asynchronous reset placed in the middle of a cycle, followed by a second release, shows that the outputs are forced at once and that the sequence restarts at cycle 0 rather than resuming.

// File: rtl/chopctl_pkg.sv
package chopctl_pkg;

  // one clock phase: the main pulse and its copy with a late falling edge
  typedef struct packed {
    logic main;
    logic late;
  } phase_t;

  // per-cycle chopper controls
  typedef struct packed {
    logic fast;
    logic ratio;
    logic fb;
    logic slow;
  } chop_t;

endpackage

// File: rtl/chopctl_tick.sv
module chopctl_tick #(
  parameter int CYC_LEN = 16,
  localparam int TW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick_o,
  output logic          wrap_o
);

  localparam logic [TW-1:0] LAST = TW'(CYC_LEN - 1);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] tick_d;

  always_comb begin
    wrap_o = (tick_q == LAST);
    if (wrap_o) tick_d = '0;
    else        tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/chopctl_window.sv
module chopctl_window
  import chopctl_pkg::*;
#(
  parameter int CYC_LEN = 16,
  parameter int START   = 0,
  parameter int STOP    = 6,
  parameter int DLY     = 1,
  localparam int TW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick_i,
  output phase_t        phase_o
);

  localparam logic [TW:0] LO      = (TW+1)'(START);
  localparam logic [TW:0] HI_MAIN = (TW+1)'(STOP);
  localparam logic [TW:0] HI_LATE = (TW+1)'(STOP + DLY);

  logic [TW:0] t_ext;
  phase_t      phase_d;
  phase_t      phase_q;

  always_comb begin
    t_ext        = {1'b0, tick_i};
    phase_d.main = (t_ext >= LO) && (t_ext < HI_MAIN);
    phase_d.late = (t_ext >= LO) && (t_ext < HI_LATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/chopctl_seq.sv
module chopctl_seq
  import chopctl_pkg::*;
#(
  parameter int SLOW_CYCLES = 10,
  parameter int ROT_CYCLES  = 2,
  parameter int NUM_UNITS   = 4,
  localparam int SW = $clog2(SLOW_CYCLES + 1),
  localparam int RW = $clog2(ROT_CYCLES + 1),
  localparam int IW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrap_i,
  output chop_t                chop_o,
  output logic [NUM_UNITS-1:0] unit_sel_o
);

  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_CYCLES - 1);
  localparam logic [RW-1:0] ROT_LAST  = RW'(ROT_CYCLES - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(NUM_UNITS - 1);

  // cycle state: describes the modulator cycle currently being timed
  logic          fast_q,  fast_d;
  logic          slow_q,  slow_d;
  logic [SW-1:0] scnt_q,  scnt_d;
  logic [RW-1:0] rcnt_q,  rcnt_d;
  logic [IW-1:0] idx_q,   idx_d;

  // registered outputs, one clock behind the state, in step with the phases
  chop_t                chop_q,  chop_d;
  logic [NUM_UNITS-1:0] sel_q,   sel_d;

  always_comb begin
    fast_d = fast_q;
    slow_d = slow_q;
    scnt_d = scnt_q;
    rcnt_d = rcnt_q;
    idx_d  = idx_q;
    if (wrap_i) begin
      fast_d = ~fast_q;
      if (scnt_q == SLOW_LAST) begin
        scnt_d = '0;
        slow_d = ~slow_q;
      end else begin
        scnt_d = scnt_q + 1'b1;
      end
      if (rcnt_q == ROT_LAST) begin
        rcnt_d = '0;
        idx_d  = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end else begin
        rcnt_d = rcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    chop_d.fast  = fast_q;
    chop_d.ratio = fast_q;
    chop_d.fb    = fast_q;
    chop_d.slow  = slow_q;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_sel
    assign sel_d[u] = (idx_q == IW'(u));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      scnt_q <= '0;
      rcnt_q <= '0;
      idx_q  <= '0;
    end else begin
      fast_q <= fast_d;
      slow_q <= slow_d;
      scnt_q <= scnt_d;
      rcnt_q <= rcnt_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chop_q <= '0;
      sel_q  <= NUM_UNITS'(1);
    end else begin
      chop_q <= chop_d;
      sel_q  <= sel_d;
    end
  end

  assign chop_o     = chop_q;
  assign unit_sel_o = sel_q;

endmodule

// File: rtl/chop_rotation_ctrl.sv
module chop_rotation_ctrl
  import chopctl_pkg::*;
#(
  parameter int CYC_LEN     = 16,
  parameter int GAP         = 2,
  parameter int DLY         = 1,
  parameter int SLOW_CYCLES = 10,
  parameter int ROT_CYCLES  = 2,
  parameter int NUM_UNITS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 phi1,
  output logic                 phi1_late,
  output logic                 phi2,
  output logic                 phi2_late,
  output logic                 fast_chop,
  output logic                 ratio_swap,
  output logic                 fb_swap,
  output logic                 slow_chop,
  output logic [NUM_UNITS-1:0] unit_sel
);

  localparam int TW   = $clog2(CYC_LEN);
  localparam int HALF = CYC_LEN / 2;

  // reset: asserted asynchronously, released on the clock
  logic rs_meta_q, rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  logic [TW-1:0] tick;
  logic          wrap;
  phase_t        ph [2];
  chop_t         chop;

  chopctl_tick #(.CYC_LEN(CYC_LEN)) u_tick (
    .clk    (clk),
    .rst_n  (rs_q),
    .tick_o (tick),
    .wrap_o (wrap)
  );

  for (genvar p = 0; p < 2; p++) begin : g_phase
    chopctl_window #(
      .CYC_LEN (CYC_LEN),
      .START   (p * HALF),
      .STOP    (p * HALF + HALF - GAP),
      .DLY     (DLY)
    ) u_win (
      .clk     (clk),
      .rst_n   (rs_q),
      .tick_i  (tick),
      .phase_o (ph[p])
    );
  end

  chopctl_seq #(
    .SLOW_CYCLES (SLOW_CYCLES),
    .ROT_CYCLES  (ROT_CYCLES),
    .NUM_UNITS   (NUM_UNITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rs_q),
    .wrap_i     (wrap),
    .chop_o     (chop),
    .unit_sel_o (unit_sel)
  );

  assign phi1       = ph[0].main;
  assign phi1_late  = ph[0].late;
  assign phi2       = ph[1].main;
  assign phi2_late  = ph[1].late;
  assign fast_chop  = chop.fast;
  assign ratio_swap = chop.ratio;
  assign fb_swap    = chop.fb;
  assign slow_chop  = chop.slow;

endmodule

// File: rtl/chop_rotation_ctrl_chk.sv
module chop_rotation_ctrl_chk #(
  parameter int NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 phi1,
  input logic                 phi1_late,
  input logic                 phi2,
  input logic                 phi2_late,
  input logic                 fast_chop,
  input logic                 ratio_swap,
  input logic                 fb_swap,
  input logic                 slow_chop,
  input logic [NUM_UNITS-1:0] unit_sel
);

  // R4: phases and their late copies never overlap
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((phi1 || phi1_late) && (phi2 || phi2_late)));

  // R5: late copy is still high in the clock where its main phase falls
  assert_late_fall1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> phi1_late);
  assert_late_fall2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> phi2_late);
  assert_late_rise1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> $rose(phi1_late));

  // R6: fast chop moves only where a modulator cycle starts
  assert_fast_on_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fast_chop) |-> $rose(phi1));

  // R7: ratio and feedback swaps follow the fast chop
  assert_swap_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_swap == fast_chop) && (fb_swap == fast_chop));

  // R8: slow chop moves only on a fast chop boundary
  assert_slow_on_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slow_chop) |-> !$stable(fast_chop));

  // R9: exactly one unit singled out, changing only on a fast chop boundary
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unit_sel) == 1);
  assert_rot_on_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_sel) |-> !$stable(fast_chop));

endmodule

bind chop_rotation_ctrl chop_rotation_ctrl_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phi1       (phi1),
  .phi1_late  (phi1_late),
  .phi2       (phi2),
  .phi2_late  (phi2_late),
  .fast_chop  (fast_chop),
  .ratio_swap (ratio_swap),
  .fb_swap    (fb_swap),
  .slow_chop  (slow_chop),
  .unit_sel   (unit_sel)
);

// File: tb/chop_rotation_ctrl_test.sv
module chop_rotation_ctrl_test;

  localparam int CYC   = 16;
  localparam int GAP   = 2;
  localparam int DLY   = 1;
  localparam int SLOW  = 10;
  localparam int ROT   = 2;
  localparam int UNITS = 4;
  localparam int HALF  = CYC / 2;
  localparam int FULL  = 2 * UNITS * ROT * CYC;  // two whole rotations, in clocks

  logic clk = 1'b0;
  logic rst_n;
  logic phi1, phi1_late, phi2, phi2_late;
  logic fast_chop, ratio_swap, fb_swap, slow_chop;
  logic [UNITS-1:0] unit_sel;

  always #5 clk = ~clk;

  chop_rotation_ctrl #(
    .CYC_LEN(CYC), .GAP(GAP), .DLY(DLY),
    .SLOW_CYCLES(SLOW), .ROT_CYCLES(ROT), .NUM_UNITS(UNITS)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .phi1(phi1), .phi1_late(phi1_late), .phi2(phi2), .phi2_late(phi2_late),
    .fast_chop(fast_chop), .ratio_swap(ratio_swap), .fb_swap(fb_swap),
    .slow_chop(slow_chop), .unit_sel(unit_sel)
  );

  typedef struct {
    int         m;   // timeline index, negative while outputs hold reset values
    logic [11:0] v;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic  mon_on   = 1'b0;
  logic  count_on = 1'b0;
  int    sel_cnt  [UNITS];
  int    swap_cnt [UNITS];

  // v: [11]phi1 [10]phi1_late [9]phi2 [8]phi2_late [7]fast [6]ratio [5]fb [4]slow [3:0]unit_sel
  function automatic logic [11:0] model(int m);
    logic [11:0] r;
    int t, k, idx;
    if (m < 0) return {8'b0, 4'b0001};
    t   = m % CYC;
    k   = m / CYC;
    idx = (k / ROT) % UNITS;
    r[11] = (t < HALF - GAP);
    r[10] = (t < HALF - GAP + DLY);
    r[9]  = (t >= HALF) && (t < CYC - GAP);
    r[8]  = (t >= HALF) && (t < CYC - GAP + DLY);
    r[7]  = k[0];
    r[6]  = k[0];
    r[5]  = k[0];
    r[4]  = ((k / SLOW) % 2) == 1;
    r[3:0] = 4'(1 << idx);
    return r;
  endfunction

  function automatic logic [11:0] observed();
    return {phi1, phi1_late, phi2, phi2_late, fast_chop, ratio_swap, fb_swap,
            slow_chop, unit_sel};
  endfunction

  task automatic check(string req, string what, logic [11:0] act, logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: push the expected timeline, then release reset between edges
  task automatic run_segment(int len, logic do_count);
    for (int n = 0; n < len; n++) begin
      item_t it;
      it.m = n - 3;  // edges 1 and 2 still in reset (R2)
      it.v = model(it.m);
      q.push_back(it);
    end
    count_on = do_count;
    @(posedge clk);
    #2 rst_n = 1'b1;
    mon_on = 1'b1;
    wait (q.size() == 0);
    mon_on = 1'b0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      item_t it;
      logic [11:0] a;
      it = q.pop_front();
      a  = observed();
      if (it.m < 0) begin
        check("R2", "held after release", a, it.v);
      end else begin
        check("R3", "main phases", {10'b0, a[11], a[9]}, {10'b0, it.v[11], it.v[9]});
        check("R5", "late phases", {10'b0, a[10], a[8]}, {10'b0, it.v[10], it.v[8]});
        check("R6", "fast chop",   {11'b0, a[7]}, {11'b0, it.v[7]});
        check("R7", "swaps",       {10'b0, a[6:5]}, {10'b0, it.v[6:5]});
        check("R8", "slow chop",   {11'b0, a[4]}, {11'b0, it.v[4]});
        check("R9", "unit select", {8'b0, a[3:0]}, {8'b0, it.v[3:0]});
        if ((a[11] || a[10]) && (a[9] || a[8])) check("R4", "overlap", a, 12'hfff);
        if (count_on && it.m < FULL) begin
          for (int u = 0; u < UNITS; u++) begin
            if (a[u]) begin
              sel_cnt[u]++;
              if (a[6]) swap_cnt[u]++;
            end
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int u = 0; u < UNITS; u++) begin
      sel_cnt[u]  = 0;
      swap_cnt[u] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 check("R1", "reset state", observed(), model(-1));

    run_segment(1500, 1'b1);

    // R10: balanced rotation over two full rotations
    for (int u = 0; u < UNITS; u++) begin
      check("R10", "unit clocks", 12'(sel_cnt[u]), 12'(FULL / UNITS));
      check("R10", "swapped clocks", 12'(swap_cnt[u]), 12'(FULL / UNITS / 2));
    end

    // R1/R11: asynchronous reset mid-cycle, then restart from cycle 0
    repeat (37) @(posedge clk);
    #3 rst_n = 1'b0;
    #1 check("R1", "async reset forces outputs", observed(), model(-1));
    repeat (2) @(posedge clk);
    #3 check("R11", "held in reset", observed(), model(-1));
    run_segment(400, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule